// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block is a small bus master that retunes one of several PLL register banks without software stepping through each access. A single start pulse brings in a prepared multiplier word and a bank index. The sequencer then works through a fixed order of steps:

- It powers the PLL down and clears its output enable.
- It loads the multiplier word, and sets the pre and post dividers to divide-by-one.
- It powers the PLL back up.
- It polls the lock flag a bounded number of times, with a programmable wait before each poll.
- Only after lock has been seen does it turn the clock output on.

The block reports the outcome as a one-cycle done pulse or a one-cycle fail pulse.

Each register bank has four word registers at a base address. Status is at base+0, control at base+4, multiplier at base+8 and divider at base+12. With the default parameters the two banks sit at 0x01C and 0x02C. Bank index 0 selects the first bank and index 1 selects the second.

Accesses use a plain request/acknowledge port. A request and its address, direction and write data stay fixed until the acknowledge is sampled high. The block works out neither the multiplier word nor the PLL's behaviour itself.

Top module: `pll_reprog_seq`

## Requirements
- R1: After reset and whenever not busy, the request, busy, done and fail outputs are low.
- R2: The first access reads control (base+4) of the selected bank. The second access writes control back with bit 0 (power-down) set, bits 1 to 4 (bypass, direct in, direct out, clock enable) cleared, and every other bit as read. The unselected bank is never accessed.
- R3: The third access writes the start multiplier word to base+8. The fourth writes 0x00302062 to base+12.
- R4: The fifth access writes control with bit 0 cleared and all other bits as in the second access.
- R5: Before every status read (base+0), the request stays low for exactly WAIT_CYC clock cycles after the preceding acknowledge.
- R6: Status is read at most POLL_MAX times. When a read returns bit 0 (lock) set, the next access writes control with bit 4 set, and done pulses after its acknowledge. No control write has bit 4 set before lock has been seen.
- R7: If POLL_MAX status reads all return lock clear, fail pulses after the last one, and no further access is made.
- R8: A request holds address, direction and write data unchanged until it is acknowledged.
- R9: A start pulse while busy is ignored and does not cause a second sequence.
- R10: Done and fail are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| bank_i | input | BANK_W | Register bank index, sampled with start |
| mdiv_i | input | DATA_W | Multiplier word, sampled with start |
| req_o | output | 1 | Bus request |
| we_o | output | 1 | Bus direction, 1 = write |
| addr_o | output | ADDR_W | Bus byte address |
| wdata_o | output | DATA_W | Bus write data |
| ack_i | input | 1 | Bus acknowledge, completes the current access |
| rdata_i | input | DATA_W | Bus read data, valid with ack |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse: PLL locked and enabled |
| fail_o | output | 1 | One-cycle pulse: no lock within the poll limit |

## Verification
The bench sweeps both banks, each lock arrival from the first poll through never locking, and several acknowledge latencies. It checks the exact access log against the expected order and data. A design that loses upper control bits, skips a wait or miscounts polls would show a wrong log entry, a wrong final control value or a wrong outcome. Lock on exactly the last poll and lock on the first poll are the edges that catch off-by-one poll limits. Zero-latency acknowledges catch a design that advances before its request is seen. A start injected mid-sequence for the other bank would corrupt that bank's model or add a second done pulse if it were not ignored.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_RD_CTRL,
    S_WR_PD,
    S_WR_MDIV,
    S_WR_NP,
    S_WR_PU,
    S_WAIT,
    S_RD_STAT,
    S_WR_EN
  } seq_state_t;

  // register word index inside a bank (byte offset = index * 4)
  typedef enum logic [1:0] {
    REG_STAT  = 2'd0,
    REG_CTRL  = 2'd1,
    REG_MDIV  = 2'd2,
    REG_NPDIV = 2'd3
  } reg_kind_t;

  localparam int CTRL_PD   = 0;
  localparam int CTRL_BYP  = 1;
  localparam int CTRL_DIN  = 2;
  localparam int CTRL_DOUT = 3;
  localparam int CTRL_EN   = 4;
  localparam int STAT_LOCK = 0;

  localparam logic [31:0] NP_UNITY = 32'h0030_2062;

endpackage

// File: rtl/pll_seq_addr.sv
module pll_seq_addr
  import pll_seq_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int NBANK  = 2,
  parameter int BANK_W = 1,
  parameter logic [NBANK*ADDR_W-1:0] BASES = '0
) (
  input  logic [BANK_W-1:0] bank,
  input  reg_kind_t         kind,
  output logic [ADDR_W-1:0] addr
);

  logic [ADDR_W-1:0] cand [NBANK];

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    assign cand[g] = BASES[g*ADDR_W +: ADDR_W] + ADDR_W'({kind, 2'b00});
  end

  always_comb begin
    addr = cand[0];
    for (int i = 0; i < NBANK; i++) begin
      if (BANK_W'(i) == bank) addr = cand[i];
    end
  end

endmodule

// File: rtl/pll_seq_timer.sv
module pll_seq_timer #(
  parameter int WAIT_CYC = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic expired
);

  localparam int CNT_W = (WAIT_CYC > 1) ? $clog2(WAIT_CYC + 1) : 1;

  logic [CNT_W-1:0] cnt;
  logic             run;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      run <= 1'b0;
    end else if (load) begin
      cnt <= CNT_W'(WAIT_CYC - 1);
      run <= 1'b1;
    end else if (run) begin
      if (cnt == '0) run <= 1'b0;
      else           cnt <= cnt - 1'b1;
    end
  end

  assign expired = run && (cnt == '0);

endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq
  import pll_seq_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 12,
  parameter int NBANK    = 2,
  parameter int BANK_W   = (NBANK > 1) ? $clog2(NBANK) : 1,
  parameter int WAIT_CYC = 20,
  parameter int POLL_MAX = 4,
  parameter logic [NBANK*ADDR_W-1:0] BANK_BASES = {12'h02C, 12'h01C}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [DATA_W-1:0] mdiv_i,
  output logic              req_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  input  logic              ack_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              fail_o
);

  localparam int POLL_W = (POLL_MAX > 1) ? $clog2(POLL_MAX + 1) : 1;
  localparam logic [DATA_W-1:0] M_PD   = DATA_W'(1) << CTRL_PD;
  localparam logic [DATA_W-1:0] M_EN   = DATA_W'(1) << CTRL_EN;
  localparam logic [DATA_W-1:0] M_MODE = (DATA_W'(1) << CTRL_BYP) | (DATA_W'(1) << CTRL_DIN)
                                       | (DATA_W'(1) << CTRL_DOUT) | M_EN;

  seq_state_t        st;
  logic [BANK_W-1:0] bank_q;
  logic [DATA_W-1:0] mdiv_q;
  logic [DATA_W-1:0] ctrl_q;
  logic [POLL_W-1:0] polls;

  reg_kind_t         kind;
  logic [BANK_W-1:0] bank_sel;
  logic [ADDR_W-1:0] nxt_addr;
  logic              xfer, lock_ok, last_poll, tmr_load, tmr_exp;
  logic [DATA_W-1:0] ctrl_down, ctrl_up;

  // register kind of the access issued on leaving the current state
  always_comb begin
    case (st)
      S_WR_PD:   kind = REG_MDIV;
      S_WR_MDIV: kind = REG_NPDIV;
      S_WAIT:    kind = REG_STAT;
      default:   kind = REG_CTRL;
    endcase
  end

  assign bank_sel  = (st == S_IDLE) ? bank_i : bank_q;
  assign xfer      = req_o && ack_i;
  assign lock_ok   = rdata_i[STAT_LOCK];
  assign last_poll = (polls == POLL_W'(POLL_MAX - 1));
  assign ctrl_down = (rdata_i | M_PD) & ~M_MODE;
  assign ctrl_up   = ctrl_q & ~M_PD;
  assign tmr_load  = xfer && ((st == S_WR_PU) || (st == S_RD_STAT && !lock_ok && !last_poll));
  assign busy_o    = (st != S_IDLE);

  pll_seq_addr #(
    .ADDR_W(ADDR_W), .NBANK(NBANK), .BANK_W(BANK_W), .BASES(BANK_BASES)
  ) u_addr (
    .bank(bank_sel), .kind(kind), .addr(nxt_addr)
  );

  pll_seq_timer #(.WAIT_CYC(WAIT_CYC)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .expired(tmr_exp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      req_o   <= 1'b0;
      we_o    <= 1'b0;
      addr_o  <= '0;
      wdata_o <= '0;
      done_o  <= 1'b0;
      fail_o  <= 1'b0;
      bank_q  <= '0;
      mdiv_q  <= '0;
      ctrl_q  <= '0;
      polls   <= '0;
    end else begin
      done_o <= 1'b0;
      fail_o <= 1'b0;
      case (st)
        S_IDLE: if (start_i) begin
          bank_q <= bank_i;
          mdiv_q <= mdiv_i;
          polls  <= '0;
          req_o  <= 1'b1;
          we_o   <= 1'b0;
          addr_o <= nxt_addr;
          st     <= S_RD_CTRL;
        end
        S_RD_CTRL: if (xfer) begin
          ctrl_q  <= ctrl_down;
          we_o    <= 1'b1;
          wdata_o <= ctrl_down;
          addr_o  <= nxt_addr;
          st      <= S_WR_PD;
        end
        S_WR_PD: if (xfer) begin
          wdata_o <= mdiv_q;
          addr_o  <= nxt_addr;
          st      <= S_WR_MDIV;
        end
        S_WR_MDIV: if (xfer) begin
          wdata_o <= DATA_W'(NP_UNITY);
          addr_o  <= nxt_addr;
          st      <= S_WR_NP;
        end
        S_WR_NP: if (xfer) begin
          ctrl_q  <= ctrl_up;
          wdata_o <= ctrl_up;
          addr_o  <= nxt_addr;
          st      <= S_WR_PU;
        end
        S_WR_PU: if (xfer) begin
          req_o <= 1'b0;
          we_o  <= 1'b0;
          st    <= S_WAIT;
        end
        S_WAIT: if (tmr_exp) begin
          req_o  <= 1'b1;
          we_o   <= 1'b0;
          addr_o <= nxt_addr;
          st     <= S_RD_STAT;
        end
        S_RD_STAT: if (xfer) begin
          if (lock_ok) begin
            ctrl_q  <= ctrl_q | M_EN;
            we_o    <= 1'b1;
            wdata_o <= ctrl_q | M_EN;
            addr_o  <= nxt_addr;
            st      <= S_WR_EN;
          end else if (last_poll) begin
            req_o  <= 1'b0;
            fail_o <= 1'b1;
            st     <= S_IDLE;
          end else begin
            polls <= polls + 1'b1;
            req_o <= 1'b0;
            st    <= S_WAIT;
          end
        end
        S_WR_EN: if (xfer) begin
          req_o  <= 1'b0;
          we_o   <= 1'b0;
          done_o <= 1'b1;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pll_reprog_seq_chk.sv
module pll_reprog_seq_chk
  import pll_seq_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 12,
  parameter int NBANK    = 2,
  parameter int WAIT_CYC = 20,
  parameter logic [NBANK*ADDR_W-1:0] BANK_BASES = {12'h02C, 12'h01C}
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic              req_o,
  input logic              we_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic [DATA_W-1:0] wdata_o,
  input logic              ack_i,
  input logic              rdata_lock,
  input logic              busy_o,
  input logic              done_o,
  input logic              fail_o
);

  function automatic logic at_kind(input logic [ADDR_W-1:0] a, input int word);
    logic hit;
    hit = 1'b0;
    for (int i = 0; i < NBANK; i++) begin
      if (a == BANK_BASES[i*ADDR_W +: ADDR_W] + ADDR_W'(word * 4)) hit = 1'b1;
    end
    return hit;
  endfunction

  logic lock_seen;
  int   gap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_seen <= 1'b0;
      gap_q     <= 0;
    end else begin
      if (start_i && !busy_o) lock_seen <= 1'b0;
      else if (req_o && ack_i && !we_o && at_kind(addr_o, 0) && rdata_lock) lock_seen <= 1'b1;
      if (req_o)        gap_q <= 0;
      else if (busy_o)  gap_q <= gap_q + 1;
    end
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> !req_o);

  a_r5_wait_before_poll: assert property (@(posedge clk) disable iff (rst)
    ($rose(req_o) && at_kind(addr_o, 0)) |-> (gap_q >= WAIT_CYC));

  a_r6_enable_after_lock: assert property (@(posedge clk) disable iff (rst)
    (req_o && we_o && at_kind(addr_o, 1) && wdata_o[CTRL_EN]) |-> lock_seen);

  a_r8_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
    (req_o && !ack_i) |=> (req_o && $stable(addr_o) && $stable(we_o) && $stable(wdata_o)));

  a_r10_not_both: assert property (@(posedge clk) disable iff (rst)
    !(done_o && fail_o));

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  a_r10_fail_pulse: assert property (@(posedge clk) disable iff (rst)
    fail_o |=> !fail_o);

endmodule

bind pll_reprog_seq pll_reprog_seq_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NBANK(NBANK),
  .WAIT_CYC(WAIT_CYC), .BANK_BASES(BANK_BASES)
) u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .req_o(req_o), .we_o(we_o),
  .addr_o(addr_o), .wdata_o(wdata_o), .ack_i(ack_i), .rdata_lock(rdata_i[0]),
  .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o)
);

// File: tb/pll_reprog_seq_tb.sv
module pll_reprog_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WAIT_CYC   = 6;
  localparam int POLL_MAX   = 4;
  localparam logic [11:0] BASE0 = 12'h01C;
  localparam logic [11:0] BASE1 = 12'h02C;
  localparam logic [31:0] NPU   = 32'h0030_2062;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [0:0]  bank_i = '0;
  logic [31:0] mdiv_i = '0;
  logic        req_o, we_o, busy_o, done_o, fail_o;
  logic [11:0] addr_o;
  logic [31:0] wdata_o;
  logic        ack_i = 1'b0;
  logic [31:0] rdata_i = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pll_reprog_seq #(
    .WAIT_CYC(WAIT_CYC), .POLL_MAX(POLL_MAX)
  ) u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .bank_i(bank_i), .mdiv_i(mdiv_i),
    .req_o(req_o), .we_o(we_o), .addr_o(addr_o), .wdata_o(wdata_o),
    .ack_i(ack_i), .rdata_i(rdata_i), .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o)
  );

  int total = 0;
  int bad   = 0;

  // register models of both banks
  logic [31:0] m_ctrl [2];
  logic [31:0] m_mdiv [2];
  logic [31:0] m_np   [2];
  int          stat_rd [2];
  int          lock_after = 1;
  int          lat = 0;
  int          ack_cnt = 0;
  int          gap = 0;
  bit          bad_addr = 0;

  int          log_n = 0;
  logic        log_we   [32];
  logic [11:0] log_addr [32];
  logic [31:0] log_wd   [32];
  int          log_gap  [32];

  int          done_cnt = 0, fail_cnt = 0;
  bit          both_seen = 0, wide_pulse = 0;
  logic        prev_done = 0, prev_fail = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // bus slave and monitor, all on the falling edge
  always @(negedge clk) begin
    if (rst) begin
      ack_i = 1'b0;
      ack_cnt = 0;
    end else begin
      if (done_o) done_cnt++;
      if (fail_o) fail_cnt++;
      if (done_o && fail_o) both_seen = 1;
      if ((done_o && prev_done) || (fail_o && prev_fail)) wide_pulse = 1;
      prev_done = done_o;
      prev_fail = fail_o;
      if (busy_o && !req_o) gap++;
      if (ack_i) begin
        ack_i = 1'b0;
        ack_cnt = 0;
      end else if (req_o) begin
        if (ack_cnt >= lat) begin
          int b;
          int w;
          ack_i = 1'b1;
          b = (addr_o >= BASE1) ? 1 : 0;
          w = int'(addr_o - (b ? BASE1 : BASE0)) / 4;
          if (addr_o < BASE0 || addr_o > BASE1 + 12 || addr_o[1:0] != 2'b00) bad_addr = 1;
          if (log_n < 32) begin
            log_we[log_n]   = we_o;
            log_addr[log_n] = addr_o;
            log_wd[log_n]   = wdata_o;
            log_gap[log_n]  = gap;
            log_n++;
          end
          gap = 0;
          if (we_o) begin
            case (w)
              1: m_ctrl[b] = wdata_o;
              2: m_mdiv[b] = wdata_o;
              3: m_np[b]   = wdata_o;
              default: bad_addr = 1;
            endcase
            rdata_i = 32'h0;
          end else begin
            case (w)
              0: begin
                stat_rd[b]++;
                rdata_i = 32'h100 | {31'h0, (!m_ctrl[b][0] && stat_rd[b] >= lock_after)};
              end
              1: rdata_i = m_ctrl[b];
              2: rdata_i = m_mdiv[b];
              default: rdata_i = m_np[b];
            endcase
          end
        end else begin
          ack_cnt++;
        end
      end
    end
  end

  task automatic run_case(input int b, input int la, input int lt);
    logic [31:0] init, mw, oth_ctrl, exp_ctrl, cb;
    bit succ;
    int nstat, waitc;
    bit ok;
    init = 32'h5A00_0000 | (32'(la) << 16) | (b ? 32'h0E : 32'h13);
    mw   = 32'h0012_3400 + 32'(la * 16 + lt + b * 256);
    oth_ctrl = 32'h0000_0015;
    cb = b ? 32'(BASE1) : 32'(BASE0);
    m_ctrl[b] = init;       m_mdiv[b] = 32'h0;      m_np[b] = 32'h0;
    m_ctrl[1-b] = oth_ctrl; m_mdiv[1-b] = 32'h1111; m_np[1-b] = 32'h2222;
    stat_rd[0] = 0; stat_rd[1] = 0;
    lock_after = la; lat = lt;
    log_n = 0; gap = 0; done_cnt = 0; fail_cnt = 0; both_seen = 0; wide_pulse = 0; bad_addr = 0;
    succ  = (la <= POLL_MAX);
    nstat = succ ? la : POLL_MAX;

    @(negedge clk);
    start_i = 1'b1; bank_i = 1'(b); mdiv_i = mw;
    @(negedge clk);
    start_i = 1'b0; mdiv_i = 32'hDEAD_BEEF;
    waitc = 0;
    while (busy_o && waitc < 3000) begin
      @(negedge clk);
      waitc++;
      // R9: a start for the other bank while busy must be ignored
      if (waitc == 4 || waitc == 30) begin
        start_i = 1'b1; bank_i = 1'(1 - b);
      end else begin
        start_i = 1'b0; bank_i = 1'(b);
      end
    end
    start_i = 1'b0;
    repeat (4) @(negedge clk);

    // R6 / R7 outcome
    check(done_cnt == (succ ? 1 : 0) && fail_cnt == (succ ? 0 : 1), "R6/R7 outcome",
          32'(done_cnt * 16 + fail_cnt), succ ? 32'h10 : 32'h01);
    // R2 read then power-down write
    ok = log_n > 1 && !log_we[0] && log_addr[0] == 12'(cb + 4) && log_we[1] &&
         log_addr[1] == 12'(cb + 4) && log_wd[1] == ((init | 32'h1) & ~32'h1E);
    check(ok, "R2 power-down", log_wd[1], (init | 32'h1) & ~32'h1E);
    // R3 multiplier and divider writes
    ok = log_n > 3 && log_we[2] && log_addr[2] == 12'(cb + 8) && log_wd[2] == mw &&
         log_we[3] && log_addr[3] == 12'(cb + 12) && log_wd[3] == NPU;
    check(ok, "R3 configure", {log_wd[2][15:0], log_wd[3][15:0]}, {mw[15:0], NPU[15:0]});
    // R4 power-up write
    ok = log_n > 4 && log_we[4] && log_addr[4] == 12'(cb + 4) && log_wd[4] == (init & ~32'h1F);
    check(ok, "R4 power-up", log_wd[4], init & ~32'h1F);
    // R5 wait before each status read, R6 poll count
    ok = (log_n == 5 + nstat + (succ ? 1 : 0));
    for (int k = 5; k < 5 + nstat && k < 32; k++) begin
      if (log_we[k] || log_addr[k] != 12'(cb) || log_gap[k] != WAIT_CYC) ok = 0;
    end
    check(ok, "R5/R6 poll count and wait", 32'(log_n), 32'(5 + nstat + (succ ? 1 : 0)));
    // R6 enable write / R7 enable left clear
    exp_ctrl = succ ? ((init & ~32'h1F) | 32'h10) : (init & ~32'h1F);
    ok = (m_ctrl[b] == exp_ctrl) && (m_mdiv[b] == mw) && (m_np[b] == NPU);
    check(ok, succ ? "R6 final control" : "R7 final control", m_ctrl[b], exp_ctrl);
    // R9 / R2 other bank untouched, no second sequence
    ok = m_ctrl[1-b] == oth_ctrl && m_mdiv[1-b] == 32'h1111 && m_np[1-b] == 32'h2222 &&
         !bad_addr && !busy_o && !req_o;
    check(ok, "R9 start ignored while busy", m_ctrl[1-b], oth_ctrl);
    // R10 pulses
    check(!both_seen && !wide_pulse, "R10 single pulses", {30'h0, both_seen, wide_pulse}, 32'h0);
    // R1 quiet after completion
    check(!req_o && !busy_o && !done_o && !fail_o, "R1 idle after run",
          {28'h0, req_o, busy_o, done_o, fail_o}, 32'h0);
  endtask

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=<200000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    m_ctrl[0] = 0; m_ctrl[1] = 0; m_mdiv[0] = 0; m_mdiv[1] = 0;
    m_np[0] = 0; m_np[1] = 0; stat_rd[0] = 0; stat_rd[1] = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!req_o && !busy_o && !done_o && !fail_o, "R1 in reset",
          {28'h0, req_o, busy_o, done_o, fail_o}, 32'h0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check(!req_o && !busy_o && !done_o && !fail_o, "R1 after reset",
          {28'h0, req_o, busy_o, done_o, fail_o}, 32'h0);
    for (int b = 0; b < 2; b++)
      for (int la = 1; la <= POLL_MAX + 1; la++)
        for (int lt = 0; lt < 3; lt++)
          run_case(b, la, lt);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule